// File: doc/BRIEF.md
# Register-Polled Nonvolatile Word Reader

This block fetches a run of consecutive 16-bit words from a nonvolatile memory controller. It reaches the controller only through one shared command/status register. A single start pulse carries a word offset and a word count. The block first checks that the whole run fits inside the memory. If it does, then for each word it writes a command that holds the word address and a start flag. It then reads the same register back at a fixed interval until a done flag shows, and takes the word from the data field of that read.

Each word leaves the block with a valid strobe and its index in the run, in ascending address order. A one-cycle done pulse closes the run. If any word's done flag fails to appear within a bounded number of reads, the run stops at that word and raises an error. Words already delivered stay valid. The error flag holds until the next accepted start.

Top module: `nvm_word_reader`

## Requirements
- R1: After reset, word_valid, done, error, reg_wr_en and reg_rd_en are all low.
- R2: A start whose offset is at or beyond MEM_WORDS, whose count is zero, or whose count exceeds MEM_WORDS minus offset raises done and error in the cycle after start and causes no register write.
- R3: For word i of a run, the block writes a command equal to ((offset + i) << ADDR_SHIFT) with bit START_BIT (default 0) set and every other bit clear.
- R4: After a read whose done bit (bit DONE_BIT, default 1) is clear, the next read of the same word comes exactly POLL_GAP + 2 cycles after the previous one.
- R5: When the done bit is set, word_data equals bits [DATA_SHIFT +: 16] of that read; the data field of a not-done read is never delivered.
- R6: Words are delivered with word_valid, with word_index counting 0 to count-1, in ascending address order.
- R7: A successful run ends with a one-cycle done pulse together with the last word, with error low.
- R8: When MAX_POLLS reads of one word all show done clear, the block raises done and error, delivers no further word and issues no further command; a word that becomes ready on read MAX_POLLS still succeeds.
- R9: A start pulse while a run is in progress is ignored.
- R10: The error flag stays high until the next start that passes the bounds check, which clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | One-cycle request to begin a run |
| offset | input | AW | First word address of the run |
| count | input | AW | Number of words in the run |
| reg_wr_en | output | 1 | Write strobe to the command/status register |
| reg_wr_data | output | REG_W | Command value written |
| reg_rd_en | output | 1 | Read strobe to the command/status register |
| reg_rd_data | input | REG_W | Register value, valid the cycle after reg_rd_en |
| word_valid | output | 1 | A read word is present |
| word_data | output | 16 | Word read from memory |
| word_index | output | AW | Position of the word within the run |
| done | output | 1 | One-cycle end-of-run pulse |
| error | output | 1 | Run rejected or timed out; held until next accepted start |

## Verification
The bench builds the block with a 32-word memory, a 3-cycle poll gap and a cap of 6 reads per word in place of the large defaults. With these values the timeout path, the last-read-succeeds boundary and a run that ends on the final memory word all come within a few hundred cycles. The responder in the bench answers with a chosen number of not-done reads per word, and it can stall one address so that it never reports done.

// File: rtl/nvmr_pkg.sv
// Shared types for the nonvolatile word reader.
// Assumes nothing beyond IEEE 1800-2017.
package nvmr_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ISSUE,
        ST_POLL,
        ST_CHECK,
        ST_GAP
    } rd_state_t;
endpackage

// File: rtl/nvmr_bounds.sv
// Range check for a requested run of words.
// Assumes offset and count are unsigned and AW bits wide; purely combinational.
module nvmr_bounds #(
    parameter int MEM_WORDS = 256,
    parameter int AW        = 9
) (
    input  logic [AW-1:0] offset,
    input  logic [AW-1:0] count,
    output logic          in_range
);
    localparam int XW = AW + 1;
    localparam logic [XW-1:0] SIZE = XW'(MEM_WORDS);

    logic [XW-1:0] off_x;
    logic [XW-1:0] cnt_x;
    logic [XW-1:0] room;

    // Words remaining after the offset, and the three rejection tests.
    always_comb begin
        off_x    = {1'b0, offset};
        cnt_x    = {1'b0, count};
        room     = (off_x < SIZE) ? (SIZE - off_x) : '0;
        in_range = (off_x < SIZE) && (cnt_x != '0) && (cnt_x <= room);
    end
endmodule

// File: rtl/nvmr_poll_timer.sv
// Counts reads of the current word and times the gap between reads.
// Assumes POLL_GAP >= 1 and MAX_POLLS >= 1.
module nvmr_poll_timer #(
    parameter int POLL_GAP  = 625,
    parameter int MAX_POLLS = 100000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic read_fire,
    input  logic gap_load,
    input  logic gap_run,
    output logic gap_zero,
    output logic last_read
);
    localparam int GW = $clog2(POLL_GAP + 1);
    localparam int PW = $clog2(MAX_POLLS + 1);

    logic [GW-1:0] gap_cnt;
    logic [PW-1:0] reads;

    // Gap counter: loaded after a not-done read, counts down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)
            gap_cnt <= '0;
        else if (gap_load)
            gap_cnt <= GW'(POLL_GAP - 1);
        else if (gap_run && gap_cnt != '0)
            gap_cnt <= gap_cnt - 1'b1;
    end

    // Read counter: restarts with each command, counts every read.
    always_ff @(posedge clk) begin
        if (!rst_n || clear)
            reads <= '0;
        else if (read_fire)
            reads <= reads + 1'b1;
    end

    assign gap_zero  = (gap_cnt == '0);
    assign last_read = (reads == PW'(MAX_POLLS));

    assert_reads_capped_R8: assert property (@(posedge clk) disable iff (!rst_n)
        reads <= PW'(MAX_POLLS));
endmodule

// File: rtl/nvmr_regfmt.sv
// Builds command words and splits read-back words for the shared register.
// Assumes the address field and data field fit inside REG_W.
module nvmr_regfmt #(
    parameter int REG_W      = 32,
    parameter int AW         = 9,
    parameter int ADDR_SHIFT = 2,
    parameter int DATA_SHIFT = 16,
    parameter int START_BIT  = 0,
    parameter int DONE_BIT   = 1
) (
    input  logic [AW-1:0]    addr,
    input  logic [REG_W-1:0] rd_word,
    output logic [REG_W-1:0] cmd,
    output logic             rd_done,
    output logic [15:0]      rd_data
);
    logic [REG_W-1:0] shifted;

    // Command: address placed in its field, plus the start flag.
    always_comb begin
        cmd = (REG_W'(addr) << ADDR_SHIFT) | (REG_W'(1) << START_BIT);
    end

    // Read-back: done flag and the data field moved down to bit 0.
    always_comb begin
        shifted = rd_word >> DATA_SHIFT;
        rd_data = shifted[15:0];
        rd_done = rd_word[DONE_BIT];
    end
endmodule

// File: rtl/nvm_word_reader.sv
// Sequencer that reads a run of words through a polled command/status register.
// Assumes the register returns read data the cycle after reg_rd_en and that
// the controller keeps the done flag set until the next command is written.
module nvm_word_reader #(
    parameter int MEM_WORDS  = 256,
    parameter int REG_W      = 32,
    parameter int ADDR_SHIFT = 2,
    parameter int DATA_SHIFT = 16,
    parameter int START_BIT  = 0,
    parameter int DONE_BIT   = 1,
    parameter int POLL_GAP   = 625,
    parameter int MAX_POLLS  = 100000,
    localparam int AW        = $clog2(MEM_WORDS) + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [AW-1:0]    offset,
    input  logic [AW-1:0]    count,
    output logic             reg_wr_en,
    output logic [REG_W-1:0] reg_wr_data,
    output logic             reg_rd_en,
    input  logic [REG_W-1:0] reg_rd_data,
    output logic             word_valid,
    output logic [15:0]      word_data,
    output logic [AW-1:0]    word_index,
    output logic             done,
    output logic             error
);
    import nvmr_pkg::*;

    rd_state_t     state;
    logic [AW-1:0] base;
    logic [AW-1:0] total;
    logic [AW-1:0] idx;
    logic          in_range;
    logic          gap_zero;
    logic          last_read;
    logic          rd_done;
    logic [15:0]   rd_word16;
    logic [AW-1:0] cur_addr;

    assign cur_addr = base + idx;

    nvmr_bounds #(.MEM_WORDS(MEM_WORDS), .AW(AW)) u_bounds (
        .offset  (offset),
        .count   (count),
        .in_range(in_range)
    );

    nvmr_poll_timer #(.POLL_GAP(POLL_GAP), .MAX_POLLS(MAX_POLLS)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (state == ST_ISSUE),
        .read_fire(state == ST_POLL),
        .gap_load (state == ST_CHECK && !rd_done),
        .gap_run  (state == ST_GAP),
        .gap_zero (gap_zero),
        .last_read(last_read)
    );

    nvmr_regfmt #(
        .REG_W(REG_W), .AW(AW), .ADDR_SHIFT(ADDR_SHIFT), .DATA_SHIFT(DATA_SHIFT),
        .START_BIT(START_BIT), .DONE_BIT(DONE_BIT)
    ) u_fmt (
        .addr   (cur_addr),
        .rd_word(reg_rd_data),
        .cmd    (reg_wr_data),
        .rd_done(rd_done),
        .rd_data(rd_word16)
    );

    assign reg_wr_en = (state == ST_ISSUE);
    assign reg_rd_en = (state == ST_POLL);

    // Run sequencer: accept, issue, poll, check, wait, and report.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ST_IDLE;
            base       <= '0;
            total      <= '0;
            idx        <= '0;
            word_valid <= 1'b0;
            word_data  <= '0;
            word_index <= '0;
            done       <= 1'b0;
            error      <= 1'b0;
        end else begin
            word_valid <= 1'b0;
            done       <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        if (in_range) begin
                            base  <= offset;
                            total <= count;
                            idx   <= '0;
                            error <= 1'b0;
                            state <= ST_ISSUE;
                        end else begin
                            done  <= 1'b1;
                            error <= 1'b1;
                        end
                    end
                end
                ST_ISSUE: state <= ST_POLL;
                ST_POLL:  state <= ST_CHECK;
                ST_CHECK: begin
                    if (rd_done) begin
                        word_valid <= 1'b1;
                        word_data  <= rd_word16;
                        word_index <= idx;
                        if (idx == total - 1'b1) begin
                            done  <= 1'b1;
                            state <= ST_IDLE;
                        end else begin
                            idx   <= idx + 1'b1;
                            state <= ST_ISSUE;
                        end
                    end else if (last_read) begin
                        done  <= 1'b1;
                        error <= 1'b1;
                        state <= ST_IDLE;
                    end else begin
                        state <= ST_GAP;
                    end
                end
                ST_GAP: if (gap_zero) state <= ST_POLL;
                default: state <= ST_IDLE;
            endcase
        end
    end

    assert_read_follows_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr_en |=> reg_rd_en);
    assert_done_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    assert_error_rises_with_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(error) |-> done);
    assert_quiet_after_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !reg_wr_en && !reg_rd_en);
    assert_index_in_run_R6: assert property (@(posedge clk) disable iff (!rst_n)
        word_valid |-> word_index < total);
    assert_error_held_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (error && !start) |=> error);
endmodule

// File: tb/tb_nvm_word_reader.sv
module tb_nvm_word_reader;
    localparam int MEM_WORDS = 32;
    localparam int GAP       = 3;
    localparam int MAXP      = 6;
    localparam int AW        = $clog2(MEM_WORDS) + 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [AW-1:0] offset = '0;
    logic [AW-1:0] count = '0;
    logic          reg_wr_en;
    logic [31:0]   reg_wr_data;
    logic          reg_rd_en;
    logic [31:0]   reg_rd_data = '0;
    logic          word_valid;
    logic [15:0]   word_data;
    logic [AW-1:0] word_index;
    logic          done;
    logic          error;

    int checks = 0;
    int fails  = 0;

    always #4 clk = ~clk;

    nvm_word_reader #(.MEM_WORDS(MEM_WORDS), .POLL_GAP(GAP), .MAX_POLLS(MAXP)) dut (
        .clk(clk), .rst_n(rst_n), .start(start), .offset(offset), .count(count),
        .reg_wr_en(reg_wr_en), .reg_wr_data(reg_wr_data), .reg_rd_en(reg_rd_en),
        .reg_rd_data(reg_rd_data), .word_valid(word_valid), .word_data(word_data),
        .word_index(word_index), .done(done), .error(error)
    );

    function automatic logic [15:0] mem_val(int a);
        return 16'h5A00 ^ 16'(a * 16'h0123);
    endfunction

    task automatic check(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Responder state, updated at the falling edge.
    int resp_addr = 0;
    int resp_reads = 0;
    int lat = 0;
    int stall_addr = -1;
    int wr_cnt = 0;
    int exp_wr_addr = 0;
    int stall_reads = 0;
    int cyc = 0;
    int last_rd_cyc = 0;
    bit last_not_ready = 1'b0;
    logic [31:0] sb_q[$];

    always @(negedge clk) begin
        cyc++;
        if (reg_wr_en) begin
            check(reg_wr_data == ((exp_wr_addr << 2) | 1), "R3 command word",
                  int'(reg_wr_data), (exp_wr_addr << 2) | 1);
            resp_addr      = int'(reg_wr_data >> 2);
            resp_reads     = 0;
            last_not_ready = 1'b0;
            wr_cnt++;
            exp_wr_addr++;
        end
        if (reg_rd_en) begin
            if (last_not_ready)
                check(cyc - last_rd_cyc == GAP + 2, "R4 poll spacing",
                      cyc - last_rd_cyc, GAP + 2);
            last_rd_cyc = cyc;
            resp_reads++;
            if (resp_addr == stall_addr) stall_reads++;
            if (resp_reads > lat && resp_addr != stall_addr) begin
                reg_rd_data    <= {mem_val(resp_addr), 14'h0, 1'b1, 1'b0};
                last_not_ready = 1'b0;
            end else begin
                reg_rd_data    <= {16'hDEAD, 14'h0, 1'b0, 1'b0};
                last_not_ready = 1'b1;
            end
        end
    end

    // Scoreboard monitor: compares each delivered word with the queue.
    always @(negedge clk) begin
        if (rst_n && word_valid) begin
            if (sb_q.size() == 0) begin
                check(1'b0, "R6 unexpected word", int'(word_index), -1);
            end else begin
                logic [31:0] e;
                e = sb_q.pop_front();
                check(word_index == AW'(e[31:16]), "R6 word index",
                      int'(word_index), int'(e[31:16]));
                check(word_data == e[15:0], "R5 word data",
                      int'(word_data), int'(e[15:0]));
            end
        end
    end

    // Driver: pushes expected words, pulses start, waits for done.
    task automatic run(int off, int cnt, int l, int stall, bit exp_err,
                       bit mid_start, string req);
        int n_ok;
        int waited;
        bit bad;
        bad = (off >= MEM_WORDS) || (cnt == 0) || (cnt > MEM_WORDS - off);
        lat = l;
        stall_addr = stall;
        wr_cnt = 0;
        stall_reads = 0;
        exp_wr_addr = off;
        n_ok = 0;
        if (!bad) begin
            for (int i = 0; i < cnt; i++) begin
                if (off + i == stall) break;
                sb_q.push_back({16'(i), mem_val(off + i)});
                n_ok++;
            end
        end
        @(negedge clk);
        offset = AW'(off);
        count  = AW'(cnt);
        start  = 1'b1;
        @(negedge clk);
        start  = 1'b0;
        waited = 1;
        while (!done && waited < 3000) begin
            if (mid_start && waited == 4) begin
                offset = 0; count = 1; start = 1'b1;
            end else begin
                start = 1'b0;
            end
            @(negedge clk);
            waited++;
        end
        start = 1'b0;
        check(done == 1'b1, {req, " done seen"}, int'(done), 1);
        if (bad) begin
            check(waited == 1, "R2 immediate reject", waited, 1);
            check(wr_cnt == 0, "R2 no command", wr_cnt, 0);
        end
        check(error == exp_err, {req, " error flag"}, int'(error), int'(exp_err));
        if (!bad) begin
            check(wr_cnt == (exp_err ? n_ok + 1 : cnt), {req, " command count"},
                  wr_cnt, exp_err ? n_ok + 1 : cnt);
        end
        repeat (2) @(negedge clk);
        check(sb_q.size() == 0, {req, " all words delivered"}, sb_q.size(), 0);
        sb_q.delete();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check({word_valid, done, error, reg_wr_en, reg_rd_en} == 5'b0, "R1 reset outputs",
              int'({word_valid, done, error, reg_wr_en, reg_rd_en}), 0);

        run(5, 1, 0, -1, 1'b0, 1'b0, "R7 single word");
        run(0, 4, 2, -1, 1'b0, 1'b0, "R4 slow responder");
        run(28, 4, 1, -1, 1'b0, 1'b0, "R6 run to last word");
        run(32, 1, 0, -1, 1'b1, 1'b0, "R2 offset at size");
        run(3, 0, 0, -1, 1'b1, 1'b0, "R2 zero count");
        run(30, 3, 0, -1, 1'b1, 1'b0, "R2 count past end");
        run(10, 4, 0, 12, 1'b1, 1'b0, "R8 timeout");
        check(stall_reads == MAXP, "R8 reads on stalled word", stall_reads, MAXP);
        repeat (5) @(negedge clk);
        check(error == 1'b1, "R10 error held", int'(error), 1);
        run(7, 2, MAXP - 1, -1, 1'b0, 1'b0, "R8 ready on last read");
        check(error == 1'b0, "R10 error cleared", int'(error), 0);
        run(16, 3, 1, -1, 1'b0, 1'b1, "R9 start while busy");

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule